// File: doc/BRIEF.md
# Float32 to Int32 Converter

This block turns an IEEE-754 single-precision bit pattern into a signed 32-bit integer. A 3-bit rounding-mode code picks how a value with a fractional part is rounded. One code value defers to a second, dynamic mode input that normally comes from a control register. Results that do not fit in a signed 32-bit integer are clamped to the nearest limit and raise the invalid flag instead of wrapping. The inexact flag reports a rounded result that differs from the operand, and it is held low whenever invalid is raised.

A width-select input sign-extends the 32-bit result across a wider output register. When the select is low, the upper bits of that register are zero. A rounding code outside the legal set raises an illegal indication and forces a quiet zero result.

The datapath has no data-dependent early exit. The latency is fixed by a parameter: either zero cycles (purely combinational) or one registered stage.

Top module: `f2i_conv`

## Requirements
- R1: Rounding codes select 000 = nearest with ties to even, 001 = toward zero, 010 = toward minus infinity, 011 = toward plus infinity, 100 = nearest with ties away from zero. Each code yields the correctly rounded integer for every finite operand.
- R2: Code 111 takes its rounding from `dyn_rm`, which uses the same encodings as R1.
- R3: A positive operand whose rounded value is 2^31 or more gives 0x7FFFFFFF with `flag_nv` = 1.
- R4: A negative operand whose rounded value is below -2^31 gives 0x80000000 with `flag_nv` = 1. An operand that rounds to exactly -2^31 gives 0x80000000 with `flag_nv` = 0.
- R5: Any NaN (exponent all ones, fraction nonzero) gives 0x7FFFFFFF. Plus infinity gives 0x7FFFFFFF and minus infinity gives 0x80000000. All three raise `flag_nv`.
- R6: `flag_nx` is 1 exactly when the rounded result differs from the operand and `flag_nv` is 0.
- R7: Subnormal operands and magnitudes below 0.5 give 0 or ±1 as the mode dictates, with `flag_nx` = 1 when the operand is nonzero. Signed zero gives 0 with no flags. A negative value that rounds to zero gives integer 0.
- R8: Rounding code 101 or 110, or code 111 with `dyn_rm` of 101, 110 or 111, sets `rm_bad` = 1. In that case the whole result is 0 and both flags are 0.
- R9: With `wide_sel` = 1, bits above 31 of `res_out` copy bit 31. With `wide_sel` = 0 those bits are 0.
- R10: With `OUT_REG` = 1, outputs are 0 during reset and show the result for an input exactly one clock edge after it is applied, for every operand value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| op_bits | input | EW+MW+1 | Floating-point operand bits |
| rm_field | input | 3 | Rounding-mode code |
| dyn_rm | input | 3 | Dynamic rounding mode used when the code is 111 |
| wide_sel | input | 1 | 1: sign-extend result over the full output |
| res_out | output | OUT_W | Integer result |
| flag_nv | output | 1 | Invalid flag |
| flag_nx | output | 1 | Inexact flag |
| rm_bad | output | 1 | Illegal rounding-mode indication |

## Verification
The bench builds the block with its defaults: an 8-bit exponent, a 23-bit fraction, a 32-bit integer, a 64-bit output and `OUT_REG` = 1. The 64-bit output brings both the sign-extension and the zero-extension paths of R9 within reach. The registered stage makes the fixed one-cycle latency and the reset value of R10 observable. Directed vectors hit ±0, ±0.5, ±1.5, ±2.5, the float neighbours of ±2^31, NaN, ±infinity and subnormals. Random operands, biased toward exponents near the integer range, are compared in all five modes against an independent remainder-versus-half model.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
   localparam logic [2:0] RM_RNE = 3'b000;
   localparam logic [2:0] RM_RTZ = 3'b001;
   localparam logic [2:0] RM_RDN = 3'b010;
   localparam logic [2:0] RM_RUP = 3'b011;
   localparam logic [2:0] RM_RMM = 3'b100;
   localparam logic [2:0] RM_DYN = 3'b111;

   function automatic logic rm_legal(input logic [2:0] code);
      return (code <= RM_RMM);
   endfunction
endpackage

// File: rtl/f2i_rm_resolve.sv
module f2i_rm_resolve
   import f2i_pkg::*;
(
   input  logic [2:0] rm_field,
   input  logic [2:0] dyn_rm,
   output logic [2:0] mode,
   output logic       bad
);
   always_comb begin
      mode = (rm_field == RM_DYN) ? dyn_rm : rm_field;
      bad  = !rm_legal(mode);
   end
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
   parameter int EW    = 8,
   parameter int MW    = 23,
   parameter int INT_W = 32
) (
   input  logic [EW+MW:0]    op,
   output logic              sign,
   output logic              is_nan,
   output logic              is_inf,
   output logic              big,
   output logic [INT_W-1:0]  mag,
   output logic              rbit,
   output logic              sticky
);
   localparam int BIAS = (1 << (EW-1)) - 1;
   localparam int FR   = MW + 2;
   localparam int TW   = INT_W + FR;
   localparam int SHW  = $clog2(INT_W + 2) + 1;

   logic [EW-1:0]          ex;
   logic [MW-1:0]          frac;
   logic [MW:0]            sig;
   logic signed [EW+1:0]   ue;
   logic                   tiny;
   logic [SHW-1:0]         sh;
   logic [TW-1:0]          fixed;

   assign ex     = op[MW +: EW];
   assign frac   = op[MW-1:0];
   assign sign   = op[EW+MW];
   assign sig    = {|ex, frac};
   assign is_nan = (&ex) && (|frac);
   assign is_inf = (&ex) && !(|frac);

   // unbiased exponent; subnormals land far below -1 and count as tiny
   assign ue   = $signed({2'b00, ex}) - $signed((EW+2)'(BIAS));
   assign big  = (ue >= $signed((EW+2)'(INT_W)));
   assign tiny = ue[EW+1] && (ue != '1);
   assign sh   = ue[SHW-1:0] + SHW'(2);

   // fixed point with FR fraction bits: value * 2^FR = sig * 2^(ue+2)
   assign fixed = TW'(sig) << sh;

   always_comb begin
      if (tiny) begin
         mag    = '0;
         rbit   = 1'b0;
         sticky = |sig;
      end else begin
         mag    = fixed[FR +: INT_W];
         rbit   = fixed[FR-1];
         sticky = |fixed[FR-2:0];
      end
   end
endmodule

// File: rtl/f2i_round_sat.sv
module f2i_round_sat
   import f2i_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic              sign,
   input  logic              is_nan,
   input  logic              is_inf,
   input  logic              big,
   input  logic [INT_W-1:0]  mag,
   input  logic              rbit,
   input  logic              sticky,
   input  logic [2:0]        mode,
   input  logic              bad,
   output logic [INT_W-1:0]  res,
   output logic              nv,
   output logic              nx
);
   localparam logic [INT_W:0]   LIM  = {2'b01, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] MAXP = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] MINN = {1'b1, {(INT_W-1){1'b0}}};

   logic             inc;
   logic             lost;
   logic [INT_W:0]   magr;
   logic             ov;

   assign lost = rbit | sticky;

   always_comb begin
      case (mode)
         RM_RNE:  inc = rbit & (sticky | mag[0]);
         RM_RDN:  inc = sign & lost;
         RM_RUP:  inc = !sign & lost;
         RM_RMM:  inc = rbit;
         default: inc = 1'b0;
      endcase
   end

   assign magr = {1'b0, mag} + (INT_W+1)'(inc);
   assign ov   = big | is_nan | is_inf | (sign ? (magr > LIM) : (magr >= LIM));

   always_comb begin
      if (bad)
         res = '0;
      else if (is_nan)
         res = MAXP;
      else if (ov)
         res = sign ? MINN : MAXP;
      else if (sign)
         res = '0 - magr[INT_W-1:0];
      else
         res = magr[INT_W-1:0];
      nv = !bad & ov;
      nx = !bad & !ov & lost;
   end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv #(
   parameter int EW      = 8,
   parameter int MW      = 23,
   parameter int INT_W   = 32,
   parameter int OUT_W   = 64,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EW+MW:0]    op_bits,
   input  logic [2:0]        rm_field,
   input  logic [2:0]        dyn_rm,
   input  logic              wide_sel,
   output logic [OUT_W-1:0]  res_out,
   output logic              flag_nv,
   output logic              flag_nx,
   output logic              rm_bad
);
   if (OUT_W < INT_W) begin : g_chk_outw
      $error("OUT_W must be at least INT_W");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_chk_reg
      $error("OUT_REG must be 0 or 1");
   end
   if (EW < 3 || MW < 2) begin : g_chk_fmt
      $error("float format too small");
   end

   logic [2:0]        mode;
   logic              bad;
   logic              sign, is_nan, is_inf, big, rbit, sticky;
   logic [INT_W-1:0]  mag;
   logic [INT_W-1:0]  res32;
   logic              nv, nx;
   logic [OUT_W-1:0]  ext;

   f2i_rm_resolve u_rm (
      .rm_field (rm_field),
      .dyn_rm   (dyn_rm),
      .mode     (mode),
      .bad      (bad)
   );

   f2i_align #(.EW(EW), .MW(MW), .INT_W(INT_W)) u_align (
      .op     (op_bits),
      .sign   (sign),
      .is_nan (is_nan),
      .is_inf (is_inf),
      .big    (big),
      .mag    (mag),
      .rbit   (rbit),
      .sticky (sticky)
   );

   f2i_round_sat #(.INT_W(INT_W)) u_rs (
      .sign   (sign),
      .is_nan (is_nan),
      .is_inf (is_inf),
      .big    (big),
      .mag    (mag),
      .rbit   (rbit),
      .sticky (sticky),
      .mode   (mode),
      .bad    (bad),
      .res    (res32),
      .nv     (nv),
      .nx     (nx)
   );

   if (OUT_W > INT_W) begin : g_ext
      assign ext = wide_sel ? {{(OUT_W-INT_W){res32[INT_W-1]}}, res32}
                            : {{(OUT_W-INT_W){1'b0}}, res32};
   end else begin : g_noext
      assign ext = res32;
   end

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_out <= '0;
            flag_nv <= 1'b0;
            flag_nx <= 1'b0;
            rm_bad  <= 1'b0;
         end else begin
            res_out <= ext;
            flag_nv <= nv;
            flag_nx <= nx;
            rm_bad  <= bad;
         end
      end
   end else begin : g_comb
      assign res_out = ext;
      assign flag_nv = nv;
      assign flag_nx = nx;
      assign rm_bad  = bad;
   end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
   parameter int EW      = 8,
   parameter int MW      = 23,
   parameter int INT_W   = 32,
   parameter int OUT_W   = 64,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EW+MW:0]    op_bits,
   input  logic [2:0]        rm_field,
   input  logic [2:0]        dyn_rm,
   input  logic              wide_sel,
   input  logic [OUT_W-1:0]  res_out,
   input  logic              flag_nv,
   input  logic              flag_nx,
   input  logic              rm_bad
);
   localparam logic [INT_W-1:0] MAXP = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] MINN = {1'b1, {(INT_W-1){1'b0}}};

   logic [EW+MW:0] d_op;
   logic [2:0]     d_rm;
   logic           d_wide;
   logic           primed;

   if (OUT_REG == 1) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_op   <= '0;
            d_rm   <= '0;
            d_wide <= 1'b0;
            primed <= 1'b0;
         end else begin
            d_op   <= op_bits;
            d_rm   <= rm_field;
            d_wide <= wide_sel;
            primed <= 1'b1;
         end
      end
   end else begin : g_nodly
      assign d_op   = op_bits;
      assign d_rm   = rm_field;
      assign d_wide = wide_sel;
      assign primed = 1'b1;
   end

   logic d_nan, d_zero;
   assign d_nan  = (&d_op[MW +: EW]) && (|d_op[MW-1:0]);
   assign d_zero = (d_op[EW+MW-1:0] == '0);

   // R6: inexact never accompanies invalid
   a_r6_nx_excludes_nv: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_nv && flag_nx));

   // R8: illegal mode is quiet
   a_r8_bad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rm_bad |-> (res_out == '0 && !flag_nv && !flag_nx));

   // R1: a static legal code never reports illegal
   a_r1_static_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && d_rm <= 3'b100) |-> !rm_bad);

   // R3: invalid result is always one of the two limits
   a_r3_sat_limits: assert property (@(posedge clk) disable iff (!rst_n)
      flag_nv |-> (res_out[INT_W-1:0] == MAXP || res_out[INT_W-1:0] == MINN));

   // R5: NaN gives the positive limit with invalid
   a_r5_nan_maxp: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && d_nan && !rm_bad) |-> (res_out[INT_W-1:0] == MAXP && flag_nv));

   // R7: signed zero is exact zero
   a_r7_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && d_zero) |-> (res_out == '0 && !flag_nv && !flag_nx));

   if (OUT_W > INT_W) begin : g_ext_chk
      // R9: upper bits follow the width select
      a_r9_sext: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && d_wide) |->
            (res_out[OUT_W-1:INT_W] == {(OUT_W-INT_W){res_out[INT_W-1]}}));
      a_r9_zext: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && !d_wide) |-> (res_out[OUT_W-1:INT_W] == '0));
   end
endmodule

bind f2i_conv f2i_conv_chk #(
   .EW(EW), .MW(MW), .INT_W(INT_W), .OUT_W(OUT_W), .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_bits = '0;
   logic [2:0]  rm_field = '0;
   logic [2:0]  dyn_rm = '0;
   logic        wide_sel = 1'b0;
   logic [63:0] res_out;
   logic        flag_nv, flag_nx, rm_bad;

   int n_vec = 0;
   int n_bad = 0;
   logic [31:0] rng = 32'h2545F491;

   always #(CLK_PERIOD/2) clk = ~clk;

   f2i_conv dut (
      .clk(clk), .rst_n(rst_n), .op_bits(op_bits), .rm_field(rm_field),
      .dyn_rm(dyn_rm), .wide_sel(wide_sel), .res_out(res_out),
      .flag_nv(flag_nv), .flag_nx(flag_nx), .rm_bad(rm_bad)
   );

   // independent model: integer part by right shift, remainder compared to half
   task automatic ref_model(input logic [31:0] f, input logic [2:0] md,
                            output logic [31:0] r, output logic nv, output logic nx);
      logic s;
      int e, ue, sh;
      longint m, ip, rem, half;
      logic up;
      s  = f[31];
      e  = int'(f[30:23]);
      nv = 1'b0; nx = 1'b0; r = '0;
      if (e == 255) begin
         nv = 1'b1;
         r  = (f[22:0] != 0 || !s) ? 32'h7FFFFFFF : 32'h80000000;
         return;
      end
      m  = (e != 0) ? (longint'(f[22:0]) + 64'sd8388608) : longint'(f[22:0]);
      ue = (e != 0) ? e - 127 : -126;
      if (ue >= 40) begin
         nv = 1'b1;
         r  = s ? 32'h80000000 : 32'h7FFFFFFF;
         return;
      end
      sh = 23 - ue;
      if (sh <= 0) begin
         ip = m << (-sh); rem = 0; half = 1;
      end else if (sh >= 60) begin
         ip = 0; rem = m; half = 64'sd1 << 61;
      end else begin
         ip = m >>> sh; rem = m - (ip << sh); half = 64'sd1 << (sh - 1);
      end
      case (md)
         3'b000:  up = (rem > half) || (rem == half && ip[0]);
         3'b010:  up = s && rem != 0;
         3'b011:  up = !s && rem != 0;
         3'b100:  up = rem >= half && rem != 0;
         default: up = 1'b0;
      endcase
      if (up) ip = ip + 1;
      if (s ? (ip > 64'sd2147483648) : (ip >= 64'sd2147483648)) begin
         nv = 1'b1;
         r  = s ? 32'h80000000 : 32'h7FFFFFFF;
      end else begin
         r  = s ? 32'(-ip) : 32'(ip);
         nx = (rem != 0);
      end
   endtask

   task automatic apply(input logic [31:0] f, input logic [2:0] rm,
                        input logic [2:0] dyn, input logic wide);
      @(negedge clk);
      op_bits = f; rm_field = rm; dyn_rm = dyn; wide_sel = wide;
      @(negedge clk);
   endtask

   task automatic compare(input string req, input logic [63:0] er,
                          input logic env, input logic enx, input logic ebad);
      n_vec++;
      if (res_out !== er || flag_nv !== env || flag_nx !== enx || rm_bad !== ebad) begin
         n_bad++;
         $display("FAIL %s op=%h rm=%b dyn=%b: got res=%h nv=%b nx=%b bad=%b, expected res=%h nv=%b nx=%b bad=%b",
                  req, op_bits, rm_field, dyn_rm, res_out, flag_nv, flag_nx, rm_bad,
                  er, env, enx, ebad);
      end
   endtask

   // apply one vector and compare against the model
   task automatic run_vec(input logic [31:0] f, input logic [2:0] rm,
                          input logic [2:0] dyn, input logic wide, input string req);
      logic [2:0] md;
      logic bad, nv, nx;
      logic [31:0] r;
      logic [63:0] er;
      md  = (rm == 3'b111) ? dyn : rm;
      bad = (md > 3'b100);
      ref_model(f, md, r, nv, nx);
      if (bad) begin
         er = '0; nv = 1'b0; nx = 1'b0;
      end else begin
         er = wide ? {{32{r[31]}}, r} : {32'h0, r};
      end
      apply(f, rm, dyn, wide);
      compare(req, er, nv, nx, bad);
   endtask

   // apply one vector and compare against a literal expectation
   task automatic run_lit(input logic [31:0] f, input logic [2:0] rm,
                          input logic [31:0] er, input logic env, input logic enx,
                          input string req);
      apply(f, rm, 3'b000, 1'b1);
      compare(req, {{32{er[31]}}, er}, env, enx, 1'b0);
   endtask

   task automatic t_reset;
      compare("R10 reset", 64'h0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_latency;
      // input set just after an edge must appear after exactly one edge
      @(negedge clk);
      op_bits = 32'h40400000; rm_field = 3'b000; wide_sel = 1'b1;
      @(posedge clk); #1;
      compare("R10 latency", 64'h3, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_modes;
      run_lit(32'h40200000, 3'b000, 32'd2,  1'b0, 1'b1, "R1 rne 2.5");
      run_lit(32'h40200000, 3'b100, 32'd3,  1'b0, 1'b1, "R1 rmm 2.5");
      run_lit(32'h3FC00000, 3'b000, 32'd2,  1'b0, 1'b1, "R1 rne 1.5");
      run_lit(32'hBFC00000, 3'b001, 32'hFFFFFFFF, 1'b0, 1'b1, "R1 rtz -1.5");
      run_lit(32'hBFC00000, 3'b010, 32'hFFFFFFFE, 1'b0, 1'b1, "R1 rdn -1.5");
      run_lit(32'hBFC00000, 3'b011, 32'hFFFFFFFF, 1'b0, 1'b1, "R1 rup -1.5");
      run_lit(32'h3F800000, 3'b011, 32'd1,  1'b0, 1'b0, "R6 exact 1.0");
      for (int md = 0; md < 5; md++) begin
         run_vec(32'h3F000000, 3'(md), 3'b000, 1'b1, "R1 0.5");
         run_vec(32'hBF000000, 3'(md), 3'b000, 1'b1, "R7 -0.5");
         run_vec(32'hC0200000, 3'(md), 3'b000, 1'b1, "R1 -2.5");
      end
   endtask

   task automatic t_dynamic;
      run_lit(32'h40200000, 3'b100, 32'd3, 1'b0, 1'b1, "R2 ref");
      for (int md = 0; md < 5; md++)
         run_vec(32'h3FC00000, 3'b111, 3'(md), 1'b1, "R2 dyn 1.5");
   endtask

   task automatic t_limits;
      run_lit(32'h4F000000, 3'b001, 32'h7FFFFFFF, 1'b1, 1'b0, "R3 +2^31");
      run_lit(32'h4EFFFFFF, 3'b011, 32'h7FFFFF80, 1'b0, 1'b0, "R3 largest fit");
      run_lit(32'h7F7FFFFF, 3'b000, 32'h7FFFFFFF, 1'b1, 1'b0, "R3 max float");
      run_lit(32'hCF000000, 3'b000, 32'h80000000, 1'b0, 1'b0, "R4 -2^31 exact");
      run_lit(32'hCF000001, 3'b011, 32'h80000000, 1'b1, 1'b0, "R4 below -2^31");
      run_lit(32'hFF7FFFFF, 3'b001, 32'h80000000, 1'b1, 1'b0, "R4 min float");
   endtask

   task automatic t_special;
      run_lit(32'h7FC00000, 3'b000, 32'h7FFFFFFF, 1'b1, 1'b0, "R5 qnan");
      run_lit(32'hFF800001, 3'b010, 32'h7FFFFFFF, 1'b1, 1'b0, "R5 neg nan");
      run_lit(32'h7F800000, 3'b001, 32'h7FFFFFFF, 1'b1, 1'b0, "R5 +inf");
      run_lit(32'hFF800000, 3'b011, 32'h80000000, 1'b1, 1'b0, "R5 -inf");
   endtask

   task automatic t_tiny;
      run_lit(32'h00000000, 3'b011, 32'h0, 1'b0, 1'b0, "R7 +0");
      run_lit(32'h80000000, 3'b010, 32'h0, 1'b0, 1'b0, "R7 -0");
      run_lit(32'h00000001, 3'b011, 32'd1, 1'b0, 1'b1, "R7 sub up");
      run_lit(32'h00000001, 3'b000, 32'd0, 1'b0, 1'b1, "R7 sub rne");
      run_lit(32'h80000001, 3'b010, 32'hFFFFFFFF, 1'b0, 1'b1, "R7 -sub down");
      run_lit(32'h80000001, 3'b011, 32'h0, 1'b0, 1'b1, "R7 -sub up");
      run_lit(32'hBE800000, 3'b001, 32'h0, 1'b0, 1'b1, "R7 -0.25 rtz");
   endtask

   task automatic t_illegal;
      run_vec(32'h3FC00000, 3'b101, 3'b000, 1'b1, "R8 code 101");
      run_vec(32'h7FC00000, 3'b110, 3'b000, 1'b1, "R8 code 110 nan");
      run_vec(32'hBFC00000, 3'b111, 3'b101, 1'b1, "R8 dyn 101");
      run_vec(32'h4F800000, 3'b111, 3'b111, 1'b1, "R8 dyn 111");
   endtask

   task automatic t_wide;
      apply(32'hC0400000, 3'b000, 3'b000, 1'b1);
      compare("R9 sext", 64'hFFFFFFFF_FFFFFFFD, 1'b0, 1'b0, 1'b0);
      apply(32'hC0400000, 3'b000, 3'b000, 1'b0);
      compare("R9 zext", 64'h00000000_FFFFFFFD, 1'b0, 1'b0, 1'b0);
      apply(32'h40400000, 3'b000, 3'b000, 1'b1);
      compare("R9 positive", 64'h3, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_random;
      logic [31:0] f;
      for (int i = 0; i < 1500; i++) begin
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         f = rng;
         if (rng[7:6] != 2'b00)
            f[30:23] = 8'(8'd118 + 8'(rng[28:24] + rng[5:1]));
         for (int md = 0; md < 5; md++)
            run_vec(f, 3'(md), 3'b000, rng[0], "R1 R6 random");
         run_vec(f, 3'b111, 3'(rng[10:8] % 5), 1'b1, "R2 random");
      end
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      t_latency;
      t_modes;
      t_dynamic;
      t_limits;
      t_special;
      t_tiny;
      t_illegal;
      t_wide;
      t_random;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule